// File: doc/BRIEF.md
# DRAM Page-Hit Request Generator

This block produces an endless stream of memory request descriptors, each an address and a read/write flag, meant to drive a DRAM controller with traffic that stays open-page friendly. Requests are issued in series of `SEQ_LEN` entries. Every series targets consecutive columns of one page in one bank of one rank, so after the first access all the others in the series are page hits.

When a series begins, the block draws a base address, a bank, a rank, a starting column and a direction from two internal LFSRs. The starting column is limited so that the whole series fits inside the page. The bank, rank and column are then written into the base address at positions chosen by a runtime map select. The address for each later request in the series is derived from the previous one.

Requests leave on a valid/ready handshake, and a byte counter records the traffic that has been accepted. If the bank count given is out of range, the block raises an error flag and produces no traffic.

Top module: `pgh_traffic_gen`

## Requirements
- R1: While reset is asserted, `req_valid` is 0, `bytes_issued` is 0 and `cfg_error` is 0.
- R2: The direction is fixed for the whole of a series. A read percentage of 0 yields only writes, 100 or more yields only reads, and a value in between (for example 50) yields both over many series.
- R3: The bank field of every request is below `cfg_util_banks`, and the rank field is below `RANKS`. Both stay the same across all requests of a series.
- R4: The first column of a series is at most `PAGE_BYTES/BLOCK_BYTES - SEQ_LEN`, and each later request in the series uses the previous column plus one.
- R5: Each address has zero block-offset bits. When `cfg_lo_addr` and `cfg_hi_addr` are multiples of 2^(block+column+bank+rank bits), each address lies in [`cfg_lo_addr`, `cfg_hi_addr`).
- R6: With `cfg_map_mode`=0 and default parameters, the fields are laid out as offset [5:0], column [9:6], bank [12:10] and rank [13]. Each later request in a series is the previous address plus `BLOCK_BYTES`.
- R7: With `cfg_map_mode`=1 and default parameters, the fields are laid out as offset [5:0], bank [8:6], rank [9] and column [13:10]. Each later request rewrites only the column field, with the old column plus one.
- R8: When `cfg_util_banks` is 0 or greater than `DRAM_BANKS`, `cfg_error` goes high, `req_valid` stays low and `bytes_issued` stays 0.
- R9: `bytes_issued` rises by `BLOCK_BYTES` on each accepted request and is unchanged on every other cycle.
- R10: While `req_valid` is high and `req_ready` is low, the address and the direction hold steady.
- R11: With a legal configuration, a new request is offered in the cycle right after each acceptance, with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_map_mode | input | 1 | Address layout select (0 or 1) |
| cfg_read_pct | input | 7 | Percentage of series that read |
| cfg_util_banks | input | 4 | Number of banks in use |
| cfg_lo_addr | input | 32 | Lower bound of base address draw |
| cfg_hi_addr | input | 32 | Exclusive upper bound of base address draw |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Consumer accepts request |
| req_addr | output | 32 | Request byte address |
| req_is_read | output | 1 | 1 = read, 0 = write |
| bytes_issued | output | 32 | Bytes of accepted requests |
| cfg_error | output | 1 | Illegal bank configuration |

## Verification
The reset release passes through two synchronizer stages, so the first request appears on the third rising edge after `rst_n` goes high. The next request and the updated `bytes_issued` both become visible right after the edge that completes a handshake. The bench changes `req_ready` one nanosecond after each rising edge and samples every output at the falling edge. It therefore decides at a falling edge that a handshake will happen, checks the address fields there, and checks the byte count at the following falling edge, by which time the register has updated.

// File: rtl/pgh_pkg.sv
package pgh_pkg;

  typedef enum logic {
    MAP_COL_LOW  = 1'b0,
    MAP_BANK_LOW = 1'b1
  } pgh_map_e;

  localparam int unsigned PCT_W    = 7;
  localparam int unsigned PCT_FULL = 100;
  localparam int unsigned PCT_MOD  = 101;

endpackage

// File: rtl/pgh_rst_sync.sv
module pgh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pgh_lfsr.sv
module pgh_lfsr #(
  parameter int unsigned       W    = 32,
  parameter logic [W-1:0]      SEED = 'h1,
  parameter logic [W-1:0]      TAPS = 'h80200003
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  // Galois shift to the right; the top tap bit keeps the state away from zero
  always_comb begin
    q_d = q >> 1;
    if (q[0]) q_d = q_d ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= q_d;
  end
endmodule

// File: rtl/pgh_addr_map.sv
module pgh_addr_map import pgh_pkg::*; #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BLOCK_BYTES = 64,
  parameter int unsigned BLK_W       = 6,
  parameter int unsigned COL_W       = 4,
  parameter int unsigned BANK_W      = 3,
  parameter int unsigned RANK_W      = 1
) (
  input  pgh_map_e            map_mode,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic [ADDR_W-1:0]   bank_val,
  input  logic [ADDR_W-1:0]   rank_val,
  input  logic [ADDR_W-1:0]   col_val,
  input  logic [ADDR_W-1:0]   cur_addr,
  output logic [ADDR_W-1:0]   start_addr,
  output logic [ADDR_W-1:0]   step_addr
);
  // layout with column directly above the block offset
  localparam int unsigned A_COL  = BLK_W;
  localparam int unsigned A_BANK = A_COL + COL_W;
  localparam int unsigned A_RANK = A_BANK + BANK_W;
  // layout with bank directly above the block offset
  localparam int unsigned B_BANK = BLK_W;
  localparam int unsigned B_RANK = B_BANK + BANK_W;
  localparam int unsigned B_COL  = B_RANK + RANK_W;

  localparam logic [ADDR_W-1:0] COL_MASK = (ADDR_W'(1) << COL_W) - ADDR_W'(1);

  function automatic logic [ADDR_W-1:0] put_field(
    input logic [ADDR_W-1:0] a,
    input int unsigned       pos,
    input int unsigned       w,
    input logic [ADDR_W-1:0] v
  );
    logic [ADDR_W-1:0] m;
    m = ((ADDR_W'(1) << w) - ADDR_W'(1)) << pos;
    return (a & ~m) | ((v << pos) & m);
  endfunction

  logic [ADDR_W-1:0] col_cur;

  always_comb begin
    start_addr = base_addr;
    step_addr  = cur_addr;
    col_cur    = (cur_addr >> B_COL) & COL_MASK;
    if (map_mode == MAP_COL_LOW) begin
      start_addr = put_field(start_addr, A_BANK, BANK_W, bank_val);
      start_addr = put_field(start_addr, A_COL,  COL_W,  col_val);
      start_addr = put_field(start_addr, A_RANK, RANK_W, rank_val);
      step_addr  = cur_addr + ADDR_W'(BLOCK_BYTES);
    end else begin
      start_addr = put_field(start_addr, B_BANK, BANK_W, bank_val);
      start_addr = put_field(start_addr, B_COL,  COL_W,  col_val);
      start_addr = put_field(start_addr, B_RANK, RANK_W, rank_val);
      step_addr  = put_field(cur_addr, B_COL, COL_W, col_cur + ADDR_W'(1));
    end
  end
endmodule

// File: rtl/pgh_traffic_gen.sv
module pgh_traffic_gen import pgh_pkg::*; #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BYTES_W     = 32,
  parameter int unsigned BLOCK_BYTES = 64,
  parameter int unsigned PAGE_BYTES  = 1024,
  parameter int unsigned DRAM_BANKS  = 8,
  parameter int unsigned RANKS       = 2,
  parameter int unsigned SEQ_LEN     = 4,
  parameter logic [31:0] SEED_A      = 32'h1D2C_3B4A,
  parameter logic [31:0] SEED_B      = 32'h6E5F_7081
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cfg_map_mode,
  input  logic [PCT_W-1:0]                         cfg_read_pct,
  input  logic [$clog2(DRAM_BANKS+1)-1:0]          cfg_util_banks,
  input  logic [ADDR_W-1:0]                        cfg_lo_addr,
  input  logic [ADDR_W-1:0]                        cfg_hi_addr,
  output logic                                     req_valid,
  input  logic                                     req_ready,
  output logic [ADDR_W-1:0]                        req_addr,
  output logic                                     req_is_read,
  output logic [BYTES_W-1:0]                       bytes_issued,
  output logic                                     cfg_error
);
  localparam int unsigned BLK_W    = $clog2(BLOCK_BYTES);
  localparam int unsigned COLS     = PAGE_BYTES / BLOCK_BYTES;
  localparam int unsigned COL_W    = $clog2(COLS);
  localparam int unsigned BANK_W   = $clog2(DRAM_BANKS);
  localparam int unsigned RANK_W   = $clog2(RANKS);
  localparam int unsigned UB_W     = $clog2(DRAM_BANKS + 1);
  localparam int unsigned SEQ_W    = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam int unsigned COL_SPAN = COLS - SEQ_LEN + 1;
  localparam int unsigned NUM_RNG  = 2;

  logic srst_n;

  pgh_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .srst_n(srst_n)
  );

  // ---------------- random sources ----------------
  logic [31:0] rng [NUM_RNG];

  for (genvar g = 0; g < NUM_RNG; g++) begin : g_rng
    pgh_lfsr #(
      .W   (32),
      .SEED((g == 0) ? SEED_A : SEED_B)
    ) u_lfsr (
      .clk  (clk),
      .rst_n(srst_n),
      .q    (rng[g])
    );
  end

  // ---------------- draws for a series start ----------------
  logic              illegal;
  logic [ADDR_W-1:0] span, raw_addr, base_addr;
  logic [15:0]       pct_draw;
  logic              dir_draw;
  logic [7:0]        ub8, bank_draw, rank_draw;
  logic [31:0]       col_src;
  logic [15:0]       col_draw;

  always_comb begin
    illegal   = (cfg_util_banks == '0) || (cfg_util_banks > UB_W'(DRAM_BANKS));
    span      = cfg_hi_addr - cfg_lo_addr;
    raw_addr  = cfg_lo_addr + ((span == '0) ? '0 : (ADDR_W'(rng[0]) % span));
    base_addr = raw_addr & ~ADDR_W'(BLOCK_BYTES - 1);
    pct_draw  = rng[1][15:0] % 16'(PCT_MOD);
    if (cfg_read_pct >= PCT_W'(PCT_FULL)) dir_draw = 1'b1;
    else                                  dir_draw = 16'(cfg_read_pct) > pct_draw;
    ub8       = 8'(cfg_util_banks);
    bank_draw = (ub8 == 8'd0) ? 8'd0 : (rng[1][23:16] % ub8);
    rank_draw = rng[1][31:24] % 8'(RANKS);
    col_src   = {rng[0][18:0], rng[0][31:19]};
    col_draw  = col_src[15:0] % 16'(COL_SPAN);
  end

  // ---------------- address construction ----------------
  logic [ADDR_W-1:0] addr_q, addr_d, start_addr, step_addr;

  pgh_addr_map #(
    .ADDR_W     (ADDR_W),
    .BLOCK_BYTES(BLOCK_BYTES),
    .BLK_W      (BLK_W),
    .COL_W      (COL_W),
    .BANK_W     (BANK_W),
    .RANK_W     (RANK_W)
  ) u_map (
    .map_mode  (pgh_map_e'(cfg_map_mode)),
    .base_addr (base_addr),
    .bank_val  (ADDR_W'(bank_draw)),
    .rank_val  (ADDR_W'(rank_draw)),
    .col_val   (ADDR_W'(col_draw)),
    .cur_addr  (addr_q),
    .start_addr(start_addr),
    .step_addr (step_addr)
  );

  // ---------------- series control, next state ----------------
  logic [SEQ_W-1:0]   left_q, left_d;
  logic               rd_q, rd_d;
  logic               vld_q, vld_d;
  logic [BYTES_W-1:0] bytes_q, bytes_d;
  logic               err_q, err_d;
  logic               hs, load;

  always_comb begin
    hs      = vld_q && req_ready;
    load    = !illegal && (!vld_q || req_ready);
    addr_d  = addr_q;
    rd_d    = rd_q;
    left_d  = left_q;
    vld_d   = vld_q;
    bytes_d = bytes_q;
    err_d   = illegal;
    if (illegal) begin
      vld_d = 1'b0;
    end else if (load) begin
      vld_d = 1'b1;
      if (left_q == '0) begin
        addr_d = start_addr;
        rd_d   = dir_draw;
        left_d = SEQ_W'(SEQ_LEN - 1);
      end else begin
        addr_d = step_addr;
        left_d = left_q - SEQ_W'(1);
      end
    end
    if (hs) bytes_d = bytes_q + BYTES_W'(BLOCK_BYTES);
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q  <= '0;
      rd_q    <= 1'b0;
      left_q  <= '0;
      vld_q   <= 1'b0;
      bytes_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (load) begin
        addr_q <= addr_d;
        rd_q   <= rd_d;
        left_q <= left_d;
      end
      if (hs) bytes_q <= bytes_d;
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign req_valid    = vld_q;
  assign req_addr     = addr_q;
  assign req_is_read  = rd_q;
  assign bytes_issued = bytes_q;
  assign cfg_error    = err_q;
endmodule

// File: rtl/pgh_traffic_gen_chk.sv
module pgh_traffic_gen_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BYTES_W     = 32,
  parameter int unsigned BLOCK_BYTES = 64,
  parameter int unsigned PAGE_BYTES  = 1024,
  parameter int unsigned DRAM_BANKS  = 8,
  parameter int unsigned RANKS       = 2,
  parameter int unsigned SEQ_LEN     = 4
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              cfg_map_mode,
  input logic [$clog2(DRAM_BANKS+1)-1:0]   cfg_util_banks,
  input logic                              req_valid,
  input logic                              req_ready,
  input logic [ADDR_W-1:0]                 req_addr,
  input logic                              req_is_read,
  input logic [BYTES_W-1:0]                bytes_issued,
  input logic                              cfg_error
);
  localparam int unsigned BLK_W  = $clog2(BLOCK_BYTES);
  localparam int unsigned COL_W  = $clog2(PAGE_BYTES / BLOCK_BYTES);
  localparam int unsigned BANK_W = $clog2(DRAM_BANKS);
  localparam int unsigned POS_W  = $clog2(SEQ_LEN + 1);
  localparam logic [ADDR_W-1:0] BANK_MASK = (ADDR_W'(1) << BANK_W) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_MASK  = ADDR_W'(BLOCK_BYTES - 1);

  logic              hs;
  logic [POS_W-1:0]  pos_q;
  logic [ADDR_W-1:0] last_addr;
  logic              last_rd;
  logic [ADDR_W-1:0] bank_fld;

  assign hs       = req_valid && req_ready;
  assign bank_fld = (req_addr >> (cfg_map_mode ? BLK_W : (BLK_W + COL_W))) & BANK_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      last_addr <= '0;
      last_rd   <= 1'b0;
    end else if (hs) begin
      pos_q     <= (pos_q == POS_W'(SEQ_LEN - 1)) ? '0 : pos_q + POS_W'(1);
      last_addr <= req_addr;
      last_rd   <= req_is_read;
    end
  end

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_is_read));

  assert_quiet_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !req_valid);

  assert_bytes_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> bytes_issued == $past(bytes_issued) + BYTES_W'(BLOCK_BYTES));

  assert_bytes_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hs |=> $stable(bytes_issued));

  assert_dir_series_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && pos_q != '0 |-> req_is_read == last_rd);

  assert_col_low_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && pos_q != '0 && !cfg_map_mode |-> req_addr == last_addr + ADDR_W'(BLOCK_BYTES));

  assert_bank_in_use_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> bank_fld < ADDR_W'(cfg_util_banks));

  assert_block_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr & OFF_MASK) == '0);

  assert_no_bubble_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !cfg_error |=> req_valid);
endmodule

bind pgh_traffic_gen pgh_traffic_gen_chk #(
  .ADDR_W     (ADDR_W),
  .BYTES_W    (BYTES_W),
  .BLOCK_BYTES(BLOCK_BYTES),
  .PAGE_BYTES (PAGE_BYTES),
  .DRAM_BANKS (DRAM_BANKS),
  .RANKS      (RANKS),
  .SEQ_LEN    (SEQ_LEN)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_map_mode  (cfg_map_mode),
  .cfg_util_banks(cfg_util_banks),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .req_is_read   (req_is_read),
  .bytes_issued  (bytes_issued),
  .cfg_error     (cfg_error)
);

// File: tb/pgh_traffic_gen_tb_top.sv
`timescale 1ns/1ps
module pgh_traffic_gen_tb_top;
  localparam int BLK     = 64;
  localparam int COLS    = 16;
  localparam int NSEQ    = 4;
  localparam int NRANK   = 2;
  localparam int LO      = 32'h0010_0000;
  localparam int HI      = 32'h0020_0000;
  // field positions stated in R6 / R7
  localparam int A_COL = 6, A_BANK = 10, A_RANK = 13;
  localparam int B_BANK = 6, B_RANK = 9, B_COL = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_map_mode = 1'b0;
  logic [6:0]  cfg_read_pct = 7'd0;
  logic [3:0]  cfg_util_banks = 4'd8;
  logic [31:0] cfg_lo_addr = LO;
  logic [31:0] cfg_hi_addr = HI;
  logic        req_valid, req_ready = 1'b0, req_is_read, cfg_error;
  logic [31:0] req_addr, bytes_issued;

  always #5 clk = ~clk;

  pgh_traffic_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_map_mode(cfg_map_mode), .cfg_read_pct(cfg_read_pct),
    .cfg_util_banks(cfg_util_banks), .cfg_lo_addr(cfg_lo_addr), .cfg_hi_addr(cfg_hi_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_is_read(req_is_read), .bytes_issued(bytes_issued), .cfg_error(cfg_error)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int fld(input logic [31:0] a, input int pos, input int w);
    return int'((a >> pos) & ((32'd1 << w) - 32'd1));
  endfunction

  typedef struct { longint exp_bytes; int force_dir; } exp_t;  // force_dir: 0 any, 1 write, 2 read
  exp_t sb_q[$];

  // monitor state
  bit          mon_on = 0, pend = 0, last_hs = 0, stalled = 0;
  int          hs_seen = 0, pos = 0, n_rd = 0, n_wr = 0;
  int          s_bank, s_rank, prev_col;
  bit          s_rd, st_rd;
  logic [31:0] prev_addr, st_addr;
  longint      exp_total = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (pend) begin
        chk(sb_q.size() > 0, "R9 queue", sb_q.size(), 1);
        if (sb_q.size() > 0) begin
          chk(bytes_issued == sb_q[0].exp_bytes, "R9 bytes", bytes_issued, sb_q[0].exp_bytes);
          void'(sb_q.pop_front());
        end
        pend = 0;
      end
      if (last_hs) chk(req_valid, "R11 no bubble", req_valid, 1);
      last_hs = 0;
      if (req_valid && stalled) begin
        chk(req_addr == st_addr && req_is_read == st_rd, "R10 hold", req_addr, st_addr);
      end
      stalled = 0;
      if (req_valid && !req_ready) begin
        stalled = 1; st_addr = req_addr; st_rd = req_is_read;
      end
      if (req_valid && req_ready) begin
        int bank, rank, col;
        if (cfg_map_mode == 1'b0) begin
          bank = fld(req_addr, A_BANK, 3); rank = fld(req_addr, A_RANK, 1); col = fld(req_addr, A_COL, 4);
        end else begin
          bank = fld(req_addr, B_BANK, 3); rank = fld(req_addr, B_RANK, 1); col = fld(req_addr, B_COL, 4);
        end
        chk(req_addr >= LO && req_addr < HI && req_addr[5:0] == 6'd0, "R5 range/align", req_addr, LO);
        chk(bank < int'(cfg_util_banks) && rank < NRANK, "R3 bank/rank legal", bank, cfg_util_banks);
        if (pos == 0) begin
          chk(col <= COLS - NSEQ, "R4 start column", col, COLS - NSEQ);
          s_bank = bank; s_rank = rank; s_rd = req_is_read;
        end else begin
          chk(bank == s_bank && rank == s_rank, "R3 same bank/rank", bank, s_bank);
          chk(col == prev_col + 1, "R4 next column", col, prev_col + 1);
          chk(req_is_read == s_rd, "R2 direction fixed", req_is_read, s_rd);
          if (cfg_map_mode == 1'b0)
            chk(req_addr == prev_addr + BLK, "R6 step", req_addr, prev_addr + BLK);
          else begin
            logic [31:0] e;
            e = (prev_addr & ~(32'hF << B_COL)) | (32'(prev_col + 1) << B_COL);
            chk(req_addr == e, "R7 column rewrite", req_addr, e);
          end
        end
        if (sb_q.size() > 0 && sb_q[0].force_dir != 0)
          chk(req_is_read == (sb_q[0].force_dir == 2), "R2 forced direction", req_is_read, sb_q[0].force_dir == 2);
        if (pos == 0) begin
          if (req_is_read) n_rd++; else n_wr++;
        end
        prev_addr = req_addr; prev_col = col;
        pos = (pos + 1) % NSEQ;
        pend = 1; last_hs = 1; hs_seen++;
      end
    end
  end

  task automatic do_reset(input bit mode, input int pct, input int ub, input bit legal);
    mon_on = 0;
    req_ready = 1'b0;
    cfg_map_mode = mode; cfg_read_pct = 7'(pct); cfg_util_banks = 4'(ub);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(req_valid == 1'b0, "R1 valid low", req_valid, 0);
    chk(bytes_issued == 0, "R1 bytes zero", bytes_issued, 0);
    chk(cfg_error == 1'b0, "R1 error low", cfg_error, 0);
    sb_q.delete();
    pend = 0; last_hs = 0; stalled = 0; pos = 0; exp_total = 0; n_rd = 0; n_wr = 0;
    rst_n = 1'b1;
    mon_on = legal;
  endtask

  task automatic run(input int n, input int pat, input int force_dir);
    int target, cyc;
    target = hs_seen + n;
    for (int i = 0; i < n; i++) begin
      exp_t it;
      exp_total += BLK;
      it.exp_bytes = exp_total; it.force_dir = force_dir;
      sb_q.push_back(it);
    end
    cyc = 0;
    while (hs_seen < target && cyc < 5000) begin
      @(posedge clk); #1;
      cyc++;
      if (hs_seen >= target) req_ready = 1'b0;
      else case (pat)
        0: req_ready = 1'b1;
        1: req_ready = cyc[0];
        default: req_ready = (cyc % 5) >= 3;
      endcase
    end
    req_ready = 1'b0;
    chk(hs_seen >= target, "R11 progress", hs_seen, target);
    repeat (2) @(negedge clk);
    chk(sb_q.size() == 0, "R9 all accepted", sb_q.size(), 0);
  endtask

  task automatic err_phase(input int ub);
    int bad;
    do_reset(1'b0, 50, ub, 1'b0);
    bad = 0;
    req_ready = 1'b1;
    repeat (16) begin
      @(negedge clk);
      if (req_valid) bad++;
    end
    req_ready = 1'b0;
    chk(bad == 0, "R8 no valid", bad, 0);
    chk(cfg_error == 1'b1, "R8 error flag", cfg_error, 1);
    chk(bytes_issued == 0, "R8 bytes zero", bytes_issued, 0);
  endtask

  initial begin
    do_reset(1'b0, 0, 8, 1'b1);
    run(24, 0, 1);               // R6 layout, all writes (R2)
    do_reset(1'b1, 100, 5, 1'b1);
    run(24, 1, 2);               // R7 layout, all reads, stalls (R10)
    do_reset(1'b0, 50, 3, 1'b1);
    run(80, 2, 0);
    chk(n_rd > 0 && n_wr > 0, "R2 mixed directions", n_rd, n_wr);
    do_reset(1'b1, 30, 1, 1'b1);
    run(20, 0, 0);
    err_phase(9);                // R8 too many banks
    err_phase(0);                // R8 zero banks
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      chk(1'b0, "WDOG timeout", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule